// File: doc/BRIEF.md
# I2C Serial Clock Generator

This block produces the serial clock of an I2C controller from the system clock. A programmable prescaler divides the system clock into a module-clock tick that occurs every `psc + 1` cycles. The low and the high half of each SCL period are timed separately in module ticks. Each half lasts its own programmed count plus a fixed extension. The extension depends only on the prescaler setting: 7 when the prescaler is 0, 6 when it is 1, and 5 for any larger value. Software normally picks the prescaler so that the module clock lands between 7 and 12 MHz.

The controller has a run control. While run is low, the block sits in a held state. In that state the three 16-bit divider registers can be written, SCL is released high and all counters are cleared. Raising run starts the clock with a low phase. A bit engine next to this block uses the one-cycle strobes that mark every falling and every rising SCL edge. Clock stretching, arbitration and data shifting belong to other blocks.

Top module: `scl_clkgen`

## Requirements
- R1: While `run_en` is low (held state), `scl_o` is 1 and both `fall_stb` and `rise_stb` are 0 from the cycle after the edge that samples `run_en` low.
- R2: A write (`cfg_we` = 1) loads `cfg_wdata` into the register chosen by `cfg_sel` only when `run_en` is low. The select codes are 0 for prescaler, 1 for low count and 2 for high count. Code 3 selects nothing. Writes while `run_en` is high have no effect on later SCL timing.
- R3: On the first clock edge that samples `run_en` high after the held state or after reset, `scl_o` goes to 0 and `fall_stb` is 1 for that cycle.
- R4: Every SCL phase duration in system cycles is its length in module ticks multiplied by `psc + 1`.
- R5: The low phase lasts `(low + d) * (psc + 1)` system cycles, counted from the cycle `scl_o` becomes 0 to the cycle it becomes 1.
- R6: The high phase lasts `(high + d) * (psc + 1)` system cycles.
- R7: The offset d is 7 for `psc` = 0, 6 for `psc` = 1 and 5 for `psc` ≥ 2.
- R8: `fall_stb` (`rise_stb`) is high for exactly one cycle: the first cycle in which `scl_o` reads 0 (1). The two strobes are never high together.
- R9: Dropping `run_en` in mid-phase releases SCL high on the next cycle without a strobe. Raising `run_en` again starts a complete fresh low phase.
- R10: A synchronous active-high `rst` clears all three registers to 0 and enters the held state. With registers at 0, both phases last 7 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | 1 = clock running, 0 = held state with configuration open |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 prescaler, 1 low count, 2 high count, 3 none |
| cfg_wdata | input | 16 | Configuration write data |
| scl_o | output | 1 | Serial clock level (1 = released) |
| fall_stb | output | 1 | One-cycle mark of an SCL falling edge |
| rise_stb | output | 1 | One-cycle mark of an SCL rising edge |

## Verification
The bench sets the prescaler to values that select each of the three offsets, including a zero low count and a zero high count. A design that used the wrong offset, or treated the count as a length off by one, would drift away from the reference on the first phase. Some writes arrive while the clock runs and some use the unused select code; a design that accepts them would change the next phase length. Run is dropped in mid-low phase and reset arrives while running. A design that kept stale prescaler or phase counts would start its next low phase short, and a design that emitted a strobe on the forced release would show a spurious rising mark.

// File: rtl/scl_clkgen_pkg.sv
package scl_clkgen_pkg;

    localparam int unsigned CFG_W = 16;
    localparam int unsigned LEN_W = CFG_W + 1;

    localparam logic [2:0] OFS_PSC0 = 3'd7;
    localparam logic [2:0] OFS_PSC1 = 3'd6;
    localparam logic [2:0] OFS_PSCN = 3'd5;

    typedef enum logic [1:0] {
        SEL_PSC  = 2'd0,
        SEL_LOW  = 2'd1,
        SEL_HIGH = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [CFG_W-1:0] psc;
        logic [CFG_W-1:0] low;
        logic [CFG_W-1:0] high;
    } scl_cfg_t;

    typedef struct packed {
        logic             started;
        logic             level;
        logic [LEN_W-1:0] ph;
        logic             fall;
        logic             rise;
    } scl_tmr_t;

    // Extension added to each phase count, chosen by the prescaler value
    function automatic logic [2:0] phase_ofs(input logic [CFG_W-1:0] psc);
        if (psc == '0)
            return OFS_PSC0;
        else if (psc == CFG_W'(1))
            return OFS_PSC1;
        else
            return OFS_PSCN;
    endfunction

    // Phase length in module ticks
    function automatic logic [LEN_W-1:0] phase_len(input logic [CFG_W-1:0] cnt,
                                                   input logic [CFG_W-1:0] psc);
        return {1'b0, cnt} + LEN_W'(phase_ofs(psc));
    endfunction

endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
    import scl_clkgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             we,
    input  logic [1:0]       sel,
    input  logic [CFG_W-1:0] wdata,
    output scl_cfg_t         cfg
);
    scl_cfg_t cfg_q;
    scl_cfg_t cfg_d;
    cfg_sel_e sel_e;

    assign sel_e = cfg_sel_e'(sel);

    // Writes open only in the held state
    always_comb begin
        cfg_d = cfg_q;
        if (we && !run_en) begin
            unique case (sel_e)
                SEL_PSC:  cfg_d.psc  = wdata;
                SEL_LOW:  cfg_d.low  = wdata;
                SEL_HIGH: cfg_d.high = wdata;
                SEL_NONE: cfg_d      = cfg_q;
                default:  cfg_d      = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else
            cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler
    import scl_clkgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [CFG_W-1:0] psc,
    output logic             tick
);
    logic [CFG_W-1:0] pcnt_q;
    logic             wrap;

    assign wrap = (pcnt_q == psc);
    assign tick = active && wrap;

    always_ff @(posedge clk) begin
        if (rst || !active)
            pcnt_q <= '0;
        else if (wrap)
            pcnt_q <= '0;
        else
            pcnt_q <= pcnt_q + CFG_W'(1);
    end
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
    import scl_clkgen_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run_en,
    input  logic     tick,
    input  scl_cfg_t cfg,
    output logic     started,
    output logic     scl,
    output logic     fall_stb,
    output logic     rise_stb
);
    scl_tmr_t         st_q;
    scl_tmr_t         st_d;
    logic [LEN_W-1:0] cur_len;
    logic             last_tick;

    assign cur_len   = st_q.level ? phase_len(cfg.high, cfg.psc)
                                  : phase_len(cfg.low,  cfg.psc);
    assign last_tick = (st_q.ph == cur_len - LEN_W'(1));

    always_comb begin
        st_d      = st_q;
        st_d.fall = 1'b0;
        st_d.rise = 1'b0;
        if (!run_en) begin
            st_d.started = 1'b0;
            st_d.level   = 1'b1;
            st_d.ph      = '0;
        end else if (!st_q.started) begin
            st_d.started = 1'b1;
            st_d.level   = 1'b0;
            st_d.ph      = '0;
            st_d.fall    = 1'b1;
        end else if (tick) begin
            if (last_tick) begin
                st_d.ph    = '0;
                st_d.level = ~st_q.level;
                st_d.fall  = st_q.level;
                st_d.rise  = ~st_q.level;
            end else begin
                st_d.ph = st_q.ph + LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= '0;
            st_q.level   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign started  = st_q.started;
    assign scl      = st_q.level;
    assign fall_stb = st_q.fall;
    assign rise_stb = st_q.rise;
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
    import scl_clkgen_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        run_en,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [15:0] cfg_wdata,
    output logic        scl_o,
    output logic        fall_stb,
    output logic        rise_stb
);
    scl_cfg_t cfg;
    logic     started;
    logic     tick;

    scl_cfg_regs u_cfg (
        .clk   (clk),
        .rst   (rst),
        .run_en(run_en),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    scl_prescaler u_psc (
        .clk   (clk),
        .rst   (rst),
        .active(run_en && started),
        .psc   (cfg.psc),
        .tick  (tick)
    );

    scl_phase_timer u_tmr (
        .clk     (clk),
        .rst     (rst),
        .run_en  (run_en),
        .tick    (tick),
        .cfg     (cfg),
        .started (started),
        .scl     (scl_o),
        .fall_stb(fall_stb),
        .rise_stb(rise_stb)
    );
endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk
    import scl_clkgen_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     run_en,
    input logic     scl_o,
    input logic     fall_stb,
    input logic     rise_stb,
    input scl_cfg_t cfg_q
);
    // R1: held state releases SCL and silences strobes
    a_r1_hold_released: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (scl_o && !fall_stb && !rise_stb));

    // R2: configuration cannot change while running
    a_r2_cfg_locked: assert property (@(posedge clk) disable iff (rst)
        run_en |=> $stable(cfg_q));

    // R3: release starts with a low phase and a falling mark
    a_r3_start_low: assert property (@(posedge clk) disable iff (rst)
        $rose(run_en) |=> (!scl_o && fall_stb));

    // R8: strobes coincide with real edges
    a_r8_fall_is_edge: assert property (@(posedge clk) disable iff (rst)
        fall_stb |-> $fell(scl_o));

    a_r8_rise_is_edge: assert property (@(posedge clk) disable iff (rst)
        rise_stb |-> $rose(scl_o));

    a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
        fall_stb |=> !fall_stb);

    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fall_stb, rise_stb}));
endmodule

bind scl_clkgen scl_clkgen_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .run_en  (run_en),
    .scl_o   (scl_o),
    .fall_stb(fall_stb),
    .rise_stb(rise_stb),
    .cfg_q   (cfg)
);

// File: tb/sim_scl_clkgen.sv
module sim_scl_clkgen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        scl_o, fall_stb, rise_stb;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_req = "R10 reset";

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_clkgen u0 (
        .clk(clk), .rst(rst), .run_en(run_en), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .scl_o(scl_o), .fall_stb(fall_stb), .rise_stb(rise_stb)
    );

    // Behavioural reference: one elapsed-cycle counter per phase
    int m_psc = 0, m_low = 0, m_high = 0, m_el = 0;
    bit m_run = 0, m_scl = 1, m_fs = 0, m_rs = 0;

    function automatic int ofs_of(int p);
        if (p == 0) return 7;
        if (p == 1) return 6;
        return 5;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_psc = 0; m_low = 0; m_high = 0;
            m_run = 0; m_scl = 1; m_fs = 0; m_rs = 0; m_el = 0;
        end else begin
            m_fs = 0; m_rs = 0;
            if (!run_en) begin
                if (cfg_we) begin
                    if (cfg_sel == 2'd0) m_psc = cfg_wdata;
                    else if (cfg_sel == 2'd1) m_low = cfg_wdata;
                    else if (cfg_sel == 2'd2) m_high = cfg_wdata;
                end
                m_run = 0; m_scl = 1; m_el = 0;
            end else if (!m_run) begin
                m_run = 1; m_scl = 0; m_el = 0; m_fs = 1;
            end else begin
                int total;
                total = ((m_scl ? m_high : m_low) + ofs_of(m_psc)) * (m_psc + 1);
                m_el++;
                if (m_el == total) begin
                    m_el = 0;
                    m_fs = m_scl;
                    m_rs = !m_scl;
                    m_scl = !m_scl;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_vec++;
            if (scl_o !== m_scl || fall_stb !== m_fs || rise_stb !== m_rs) begin
                n_bad++;
                $display("FAIL %s t=%0t: scl/fall/rise actual %b%b%b expected %b%b%b",
                         cur_req, $time, scl_o, fall_stb, rise_stb, m_scl, m_fs, m_rs);
            end
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int sel, int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = 16'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(int p, int lo, int hi);
        @(negedge clk); run_en = 1'b0;
        wr(0, p); wr(1, lo); wr(2, hi);
    endtask

    // Direct measurement of phase durations from release
    task automatic measure(int exp_lo, int exp_hi);
        int n;
        @(negedge clk); run_en = 1'b1;
        n = 0;
        while (!fall_stb && n < 1000) begin @(negedge clk); n++; end
        n = 0;
        do begin @(negedge clk); n++; end while (!rise_stb && n < 100000);
        n_vec++;
        if (n != exp_lo) begin
            n_bad++;
            $display("FAIL R5 low length actual %0d expected %0d", n, exp_lo);
        end
        n = 0;
        do begin @(negedge clk); n++; end while (!fall_stb && n < 100000);
        n_vec++;
        if (n != exp_hi) begin
            n_bad++;
            $display("FAIL R6 high length actual %0d expected %0d", n, exp_hi);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cur_req = "R10 reset state";
        cycles(3);
        rst = 1'b0;
        cur_req = "R1 held";
        cycles(5);
        cur_req = "R10 default registers give 7/7";
        run_en = 1'b1;
        cycles(60);

        cur_req = "R7 offset 7 with psc 0, R5 low, R6 high";
        setup(0, 2, 4);
        cur_req = "R3 start low";
        run_en = 1'b1;
        cur_req = "R7 offset 7 with psc 0, R5 low, R6 high";
        cycles(80);

        cur_req = "R7 offset 6 with psc 1, R4 prescale";
        setup(1, 3, 1);
        measure(18, 14);
        cycles(40);

        cur_req = "R7 offset 5 with psc 2, R5 zero low count";
        setup(2, 0, 2);
        run_en = 1'b1;
        cycles(100);

        cur_req = "R7 offset 5 with psc 4, R6 zero high count";
        setup(4, 1, 0);
        run_en = 1'b1;
        cycles(120);

        cur_req = "R2 writes ignored while running";
        wr(0, 0); wr(1, 9); wr(2, 9);
        cycles(120);

        cur_req = "R2 select 3 writes nothing";
        @(negedge clk); run_en = 1'b0;
        wr(3, 16'hFFFF);
        run_en = 1'b1;
        cycles(120);

        cur_req = "R9 drop run in mid low phase";
        setup(1, 4, 2);
        run_en = 1'b1;
        cycles(8);
        run_en = 1'b0;
        cycles(4);
        cur_req = "R9 fresh low phase after re-release";
        run_en = 1'b1;
        cycles(80);

        cur_req = "R10 reset while running";
        rst = 1'b1;
        cycles(2);
        rst = 1'b0;
        cycles(60);

        cur_req = "R8 strobes on edges";
        cycles(20);
        finish_run();
    end
endmodule